// File: doc/BRIEF.md
# Micro Program Counter with One-Level Return

This block holds the address of the current microinstruction in a microcoded control unit. On every clock edge a 3-bit selector from the running microinstruction picks where the sequencer goes next. It can step to the following address, enter the routine that one of two opcode/mode mapping tables points at, restart at address zero, or branch to an address carried in the microinstruction. It can also branch while remembering where to come back to, and later resume at that remembered address.

The address register feeds the microcode store directly, so a change of selector shows up on `useq_addr` one edge later. A single return register holds the link for one level of micro-subroutine. The return register is visible at the ports. An address of zero means a new machine instruction begins, and the block reports this on `at_fetch`.

Top module: `micro_seq_pc`

## Requirements
- R1: While `rst_n` is low, `useq_addr` and `link_addr` are 0 and `at_fetch` is 1.
- R2: Selector 3'b000 sets `useq_addr` to its value plus one on the next edge. From 127 it wraps to 0.
- R3: Selector 3'b001 loads `map_a` into `useq_addr`. Selector 3'b010 loads `map_b`.
- R4: Selector 3'b011 sets `useq_addr` to 0.
- R5: Selector 3'b100 loads `jump_addr` into `useq_addr`.
- R6: Selector 3'b101 loads the value `link_addr` held before the edge into `useq_addr`.
- R7: Selector 3'b110 loads `jump_addr` into `useq_addr`. On the same edge it writes the prior `useq_addr` plus one, modulo 128, into `link_addr`. From 127 the link written is 0.
- R8: Selector 3'b111 leaves `useq_addr` unchanged, whatever the values on `map_a`, `map_b` and `jump_addr`.
- R9: `link_addr` changes on selector 3'b110 and under reset, and on no other selector.
- R10: `at_fetch` is 1 exactly when `useq_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel | input | 3 | Next-address selector from the microinstruction |
| map_a | input | 7 | Entry address from the first mapping table |
| map_b | input | 7 | Entry address from the second mapping table |
| jump_addr | input | 7 | Branch address field of the microinstruction |
| useq_addr | output | 7 | Current micro address, driven straight from the register |
| link_addr | output | 7 | Saved return address |
| at_fetch | output | 1 | High while the micro address is zero |

## Verification
Every selector takes effect on the first rising edge after it is presented. `useq_addr` and `link_addr` therefore settle one cycle after the inputs change, and `at_fetch` follows in the same cycle with no further register. The driver applies each vector at the falling edge and queues the state expected after the next rising edge. The monitor pops one entry 1 ns after each rising edge and compares all three outputs there. Each result is checked in the cycle its register is loaded, and a late or early update shows up as a miscompare.

// File: rtl/upc_pkg.sv
package upc_pkg;

  // Next-address selector encoding (decoded by the microinstruction field)
  typedef enum logic [2:0] {
    SEL_STEP  = 3'b000,
    SEL_MAPA  = 3'b001,
    SEL_MAPB  = 3'b010,
    SEL_ZERO  = 3'b011,
    SEL_JUMP  = 3'b100,
    SEL_BACK  = 3'b101,
    SEL_CALL  = 3'b110,
    SEL_STAY  = 3'b111
  } upc_sel_e;

endpackage

// File: rtl/upc_next_sel.sv
module upc_next_sel #(
  parameter int ADDR_W = 7
) (
  input  upc_pkg::upc_sel_e  sel,
  input  logic [ADDR_W-1:0]  cur,
  input  logic [ADDR_W-1:0]  link,
  input  logic [ADDR_W-1:0]  map_a,
  input  logic [ADDR_W-1:0]  map_b,
  input  logic [ADDR_W-1:0]  jump_addr,
  output logic [ADDR_W-1:0]  nxt,
  output logic [ADDR_W-1:0]  cur_plus1,
  output logic               call_evt,
  output logic               back_evt,
  output logic               wrap_evt
);
  import upc_pkg::*;

  localparam logic [ADDR_W-1:0] ADDR_TOP = '1;

  // Modulo-2^ADDR_W successor
  function automatic logic [ADDR_W-1:0] addr_succ(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  assign cur_plus1 = addr_succ(cur);
  assign call_evt  = (sel == SEL_CALL);
  assign back_evt  = (sel == SEL_BACK);
  assign wrap_evt  = (sel == SEL_STEP) && (cur == ADDR_TOP);

  always_comb begin
    unique case (sel)
      SEL_STEP: nxt = cur_plus1;
      SEL_MAPA: nxt = map_a;
      SEL_MAPB: nxt = map_b;
      SEL_ZERO: nxt = '0;
      SEL_JUMP: nxt = jump_addr;
      SEL_BACK: nxt = link;
      SEL_CALL: nxt = jump_addr;
      default:  nxt = cur;
    endcase
  end

endmodule

// File: rtl/upc_link_reg.sv
module upc_link_reg #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              save_en,
  input  logic [ADDR_W-1:0] save_val,
  output logic [ADDR_W-1:0] link_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       link_q <= '0;
    else if (save_en) link_q <= save_val;
  end

  // R9: link is untouched unless a call is decoded
  assert_link_only_on_call_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !save_en |=> $stable(link_q));

endmodule

// File: rtl/micro_seq_pc.sv
module micro_seq_pc #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        sel,
  input  logic [ADDR_W-1:0] map_a,
  input  logic [ADDR_W-1:0] map_b,
  input  logic [ADDR_W-1:0] jump_addr,
  output logic [ADDR_W-1:0] useq_addr,
  output logic [ADDR_W-1:0] link_addr,
  output logic              at_fetch
);
  import upc_pkg::*;

  upc_sel_e          sel_e;
  logic [ADDR_W-1:0] upc_q;
  logic [ADDR_W-1:0] upc_d;
  logic [ADDR_W-1:0] link_q;
  logic [ADDR_W-1:0] succ;
  logic              call_evt;
  logic              back_evt;
  logic              wrap_evt;

  assign sel_e = upc_sel_e'(sel);

  upc_next_sel #(.ADDR_W(ADDR_W)) u_next (
    .sel       (sel_e),
    .cur       (upc_q),
    .link      (link_q),
    .map_a     (map_a),
    .map_b     (map_b),
    .jump_addr (jump_addr),
    .nxt       (upc_d),
    .cur_plus1 (succ),
    .call_evt  (call_evt),
    .back_evt  (back_evt),
    .wrap_evt  (wrap_evt)
  );

  upc_link_reg #(.ADDR_W(ADDR_W)) u_link (
    .clk      (clk),
    .rst_n    (rst_n),
    .save_en  (call_evt),
    .save_val (succ),
    .link_q   (link_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upc_q <= '0;
    else        upc_q <= upc_d;
  end

  assign useq_addr = upc_q;
  assign link_addr = link_q;
  assign at_fetch  = (upc_q == '0);

  // R2: stepping past the top address lands on zero
  assert_wrap_to_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (useq_addr == '0));

  // R5: plain branch takes the microinstruction address
  assert_jump_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_e == SEL_JUMP) |=> (useq_addr == $past(jump_addr)));

  // R6: return resumes at the saved link
  assert_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
    back_evt |=> (useq_addr == $past(link_addr)));

  // R7: call links the successor and branches
  assert_call_link_R7: assert property (@(posedge clk) disable iff (!rst_n)
    call_evt |=> (link_addr == ADDR_W'($past(useq_addr) + ADDR_W'(1)))
                 && (useq_addr == $past(jump_addr)));

  // R8: stay holds the address
  assert_stay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_e == SEL_STAY) |=> $stable(useq_addr));

  // R4: clear
  assert_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_e == SEL_ZERO) |=> at_fetch);

endmodule

// File: tb/tb_micro_seq_pc.sv
module tb_micro_seq_pc;

  localparam int AW   = 7;
  localparam int TOPA = 127;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    sel = 3'b111;
  logic [AW-1:0] map_a = '0;
  logic [AW-1:0] map_b = '0;
  logic [AW-1:0] jump_addr = '0;
  logic [AW-1:0] useq_addr;
  logic [AW-1:0] link_addr;
  logic          at_fetch;

  int n_vec  = 0;
  int n_miss = 0;
  bit done   = 0;

  // Reference state
  int m_pc  = 0;
  int m_lnk = 0;

  // Scoreboard queues
  int    q_pc[$];
  int    q_lnk[$];
  string q_tag[$];

  always #2 clk = ~clk;

  micro_seq_pc #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .sel(sel),
    .map_a(map_a), .map_b(map_b), .jump_addr(jump_addr),
    .useq_addr(useq_addr), .link_addr(link_addr), .at_fetch(at_fetch)
  );

  task automatic check(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_miss++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic apply(input int s, input int a, input int b, input int j, input string tag);
    @(negedge clk);
    sel = 3'(s); map_a = 7'(a); map_b = 7'(b); jump_addr = 7'(j);
    case (s)
      0: m_pc = (m_pc == TOPA) ? 0 : m_pc + 1;
      1: m_pc = a;
      2: m_pc = b;
      3: m_pc = 0;
      4: m_pc = j;
      5: m_pc = m_lnk;
      6: begin m_lnk = (m_pc + 1) % (TOPA + 1); m_pc = j; end
      default: ;
    endcase
    q_pc.push_back(m_pc);
    q_lnk.push_back(m_lnk);
    q_tag.push_back(tag);
  endtask

  // Monitor: compare 1 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_pc.size() > 0) begin
        int    ep;
        int    el;
        string t;
        ep = q_pc.pop_front();
        el = q_lnk.pop_front();
        t  = q_tag.pop_front();
        check({t, " addr"}, int'(useq_addr), ep);
        check({t, " link R9"}, int'(link_addr), el);
        check({t, " fetch R10"}, int'(at_fetch), (ep == 0) ? 1 : 0);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    n_miss++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state, with inputs that would otherwise move the counter
    sel = 3'b100; jump_addr = 7'd55;
    repeat (3) @(posedge clk);
    #1;
    check("R1 addr", int'(useq_addr), 0);
    check("R1 link", int'(link_addr), 0);
    check("R1 fetch", int'(at_fetch), 1);
    @(negedge clk);
    sel = 3'b111;
    rst_n = 1'b1;

    // R2 step from reset
    apply(0, 9, 9, 9, "R2 step");
    apply(0, 9, 9, 9, "R2 step");
    // R3 mapping loads
    apply(1, 125, 3, 60, "R3 map_a");
    apply(0, 0, 0, 0, "R2 step");
    apply(0, 0, 0, 0, "R2 step to top");
    apply(0, 0, 0, 0, "R2 wrap");
    apply(0, 0, 0, 0, "R2 step after wrap");
    apply(2, 100, 44, 7, "R3 map_b");
    // R4 clear
    apply(3, 1, 2, 3, "R4 clear");
    // R5 jump
    apply(4, 11, 22, 90, "R5 jump");
    // R7 call from 90: link 91
    apply(6, 5, 6, 30, "R7 call");
    apply(0, 0, 0, 0, "R2 step in sub");
    // R9: non-call selectors leave link alone
    apply(1, 70, 0, 0, "R9 map_a");
    apply(3, 0, 0, 0, "R9 clear");
    apply(4, 0, 0, 12, "R9 jump");
    // R6 return
    apply(5, 1, 2, 3, "R6 return");
    // R8 hold with changing inputs
    for (int i = 0; i < 6; i++)
      apply(7, int'($urandom_range(0, 127)), int'($urandom_range(0, 127)),
            int'($urandom_range(0, 127)), "R8 stay");
    // R7 call from the top address links 0
    apply(4, 0, 0, 127, "R5 jump top");
    apply(6, 0, 0, 64, "R7 call at top");
    apply(5, 0, 0, 0, "R6 return to zero");
    // R7 call twice: second overwrites
    apply(4, 0, 0, 20, "R5 jump");
    apply(6, 0, 0, 40, "R7 call a");
    apply(6, 0, 0, 50, "R7 call b");
    apply(5, 0, 0, 0, "R6 return");
    // Mixed random sequence
    for (int i = 0; i < 40; i++)
      apply(int'($urandom_range(0, 7)), int'($urandom_range(0, 127)),
            int'($urandom_range(0, 127)), int'($urandom_range(0, 127)), "mixed R2-R8");
    apply(7, 0, 0, 0, "R8 stay");
    repeat (3) @(posedge clk);
    #2;
    finish_run();
  end

endmodule